// File: doc/BRIEF.md
# Two-Button Sequence Lock with Press Synchronisation

This block opens a lock once the four-symbol sequence 0, 1, 1, 0 has been keyed on two push buttons. One button enters a 0 and the other a 1. The button levels arrive with no timing relation to the clock and may stay high for any number of cycles. Each level therefore passes through a multi-flop synchroniser before the sequence logic sees it.

The sequence logic is a Moore machine. After it accepts a press, it moves to a waiting condition and stays there until both buttons read low. A button held for a long time therefore counts as exactly one symbol. A wrong symbol does not always restart the search: the machine keeps whatever tail of the keyed history still forms a prefix of the code. The open flag is registered and depends only on the matched state.

Top module: `twobtn_seq_lock`

## Requirements
- R1: `unlock` is 1 exactly when the last four accepted symbols, oldest first, were 0, 1, 1, 0, where a press of `key0_raw` enters symbol 0 and a press of `key1_raw` enters symbol 1.
- R2: While `rst` is high at a clock edge, the machine returns to the nothing-matched state, and `unlock` reads 0 after that edge.
- R3: Each raw button passes through SYNC_STAGES flops (default 2). With the defaults, an accepted press that completes the code raises `unlock` on the third rising edge after the raw level rises, and not on the second.
- R4: A button held high for any number of cycles enters exactly one symbol.
- R5: After a press is accepted, no further symbol is taken until both synchronised buttons have read 0 in the same cycle.
- R6: If both synchronised buttons read 1 in a cycle where a press could be accepted, no symbol is entered. The machine then waits until both buttons are released.
- R7: A wrong symbol uses overlap recovery. A 0 from "seen 0", "seen 01" or "seen 0110" leads to "seen 0". A 1 from "seen 0110" leads to "seen 01". A 1 from "seen 011" leads to nothing matched. A 1 from nothing matched stays there.
- R8: Once high, `unlock` stays high through holds and releases until the next symbol is accepted.
- R9: `unlock` changes only in a cycle that accepts a symbol or applies reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key0_raw | input | 1 | Raw level of the button that enters symbol 0 |
| key1_raw | input | 1 | Raw level of the button that enters symbol 1 |
| unlock | output | 1 | Registered open flag |

## Verification
The bench runs every press sequence of one to six symbols from reset and compares `unlock` against a shift-register model of the last four symbols, both while the button is held and after it is released. A design that re-accepts a held button would enter repeated symbols and open or stay shut at the wrong times. A design with a wrong overlap arc would miss codes such as 0110110. Directed cases cover:
- a very long hold;
- both buttons pressed together, which must not disturb the matched prefix or an open lock;
- one button handed over to the other while still held, which must count once;
- the exact edge on which `unlock` responds, which catches a missing or extra synchroniser stage.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

   typedef enum logic [2:0] {
      MT_NONE = 3'd0,
      MT_0    = 3'd1,
      MT_01   = 3'd2,
      MT_011  = 3'd3,
      MT_0110 = 3'd4
   } match_t;

   // Overlap-preserving advance of the matched prefix by one symbol.
   function automatic match_t match_step(match_t cur, logic sym);
      match_t nxt;
      case (cur)
         MT_NONE: nxt = sym ? MT_NONE : MT_0;
         MT_0:    nxt = sym ? MT_01   : MT_0;
         MT_01:   nxt = sym ? MT_011  : MT_0;
         MT_011:  nxt = sym ? MT_NONE : MT_0110;
         MT_0110: nxt = sym ? MT_01   : MT_0;
         default: nxt = MT_NONE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/keylock_sync.sv
module keylock_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("keylock_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("keylock_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= '0;
         else     chain <= {chain[TOP-1:0], d_async[i]};
      end
      assign q_sync[i] = chain[TOP];
   end

endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
   import keylock_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic key0,
   input  logic key1,
   output logic unlock
);

   match_t match_q, match_d;
   logic   busy_q, busy_d;
   logic   unlock_q;
   logic   any_key;

   assign any_key = key0 | key1;

   always_comb begin
      match_d = match_q;
      busy_d  = busy_q;
      if (busy_q) begin
         if (!any_key) busy_d = 1'b0;
      end else if (key0 && key1) begin
         busy_d = 1'b1;
      end else if (key0) begin
         match_d = match_step(match_q, 1'b0);
         busy_d  = 1'b1;
      end else if (key1) begin
         match_d = match_step(match_q, 1'b1);
         busy_d  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         match_q  <= MT_NONE;
         busy_q   <= 1'b0;
         unlock_q <= 1'b0;
      end else begin
         match_q  <= match_d;
         busy_q   <= busy_d;
         unlock_q <= (match_d == MT_0110);
      end
   end

   assign unlock = unlock_q;

   // R2
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (match_q == MT_NONE) && !unlock_q && !busy_q);

   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && any_key) |=> $stable(match_q) && busy_q);

   // R6
   both_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && key0 && key1) |=> $stable(match_q) && busy_q);

   // R4
   accept_arms_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && (key0 ^ key1)) |=> busy_q);

   // R7
   open_from_011_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(unlock_q) |-> ($past(match_q) == MT_011) && !$past(key1));

   // R8
   unlock_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (unlock_q && busy_q) |=> unlock_q);

   // R9
   moore_stable_chk: assert property (@(posedge clk) disable iff (rst)
      busy_q |=> $stable(unlock_q));

endmodule

// File: rtl/twobtn_seq_lock.sv
module twobtn_seq_lock #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic key0_raw,
   input  logic key1_raw,
   output logic unlock
);

   localparam int NKEYS = 2;

   logic [NKEYS-1:0] keys_sync;

   keylock_sync #(
      .WIDTH  (NKEYS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async ({key1_raw, key0_raw}),
      .q_sync  (keys_sync)
   );

   keylock_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .key0   (keys_sync[0]),
      .key1   (keys_sync[1]),
      .unlock (unlock)
   );

endmodule

// File: tb/sim_twobtn_seq_lock.sv
module sim_twobtn_seq_lock;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic k0 = 1'b0;
   logic k1 = 1'b0;
   logic unlock;

   int checks = 0;
   int errors = 0;
   logic [3:0] hist;
   int cnt;
   logic done = 1'b0;

   always #5 clk = ~clk;

   twobtn_seq_lock u0 (
      .clk      (clk),
      .rst      (rst),
      .key0_raw (k0),
      .key1_raw (k1),
      .unlock   (unlock)
   );

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s unlock=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; k0 = 1'b0; k1 = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      hist = 4'b0; cnt = 0;
   endtask

   function automatic logic model_exp();
      return (cnt >= 4) && (hist == 4'b0110);
   endfunction

   task automatic model_push(input logic s);
      hist = {hist[2:0], s};
      cnt++;
   endtask

   // press one button, hold it, release it; check while held and after release
   task automatic press(input logic s, input int hold, input string req);
      @(negedge clk);
      if (s) k1 = 1'b1; else k0 = 1'b1;
      model_push(s);
      repeat (hold) @(negedge clk);
      check(unlock, model_exp(), req);
      k0 = 1'b0; k1 = 1'b0;
      repeat (4) @(negedge clk);
      check(unlock, model_exp(), req);
   endtask

   task automatic press_both(input string req);
      @(negedge clk);
      k0 = 1'b1; k1 = 1'b1;
      repeat (6) @(negedge clk);
      check(unlock, model_exp(), req);
      k0 = 1'b0; k1 = 1'b0;
      repeat (4) @(negedge clk);
      check(unlock, model_exp(), req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      check(unlock, 1'b0, "R2 reset state");

      // R1 R7: every sequence of 1..6 symbols against the last-four model
      for (int len = 1; len <= 6; len++) begin
         for (int p = 0; p < (1 << len); p++) begin
            do_reset();
            for (int i = len - 1; i >= 0; i--) begin
               press(p[i] ? 1'b1 : 1'b0, 4, "R1 R7 sweep");
            end
         end
      end

      // R7: overlap chain 0110110 opens twice
      do_reset();
      press(0, 4, "R7"); press(1, 4, "R7"); press(1, 4, "R7"); press(0, 4, "R7");
      check(unlock, 1'b1, "R7 first open");
      press(1, 4, "R7"); press(1, 4, "R7"); press(0, 4, "R7");
      check(unlock, 1'b1, "R7 overlap reopen");

      // R4: a long hold of symbol 1 counts once
      do_reset();
      press(0, 4, "R4"); press(1, 60, "R4"); press(1, 4, "R4"); press(0, 4, "R4");
      check(unlock, 1'b1, "R4 long hold once");

      // R6: both together leave the prefix untouched; then with lock open
      do_reset();
      press(0, 4, "R6"); press(1, 4, "R6"); press(1, 4, "R6");
      press_both("R6 both ignored");
      press(0, 4, "R6");
      check(unlock, 1'b1, "R6 prefix kept");
      press_both("R8 both while open");
      check(unlock, 1'b1, "R8 stays open");

      // R5: B0 pressed, B1 added, B0 released, B1 released = single 0
      do_reset();
      press(0, 4, "R5"); press(1, 4, "R5"); press(1, 4, "R5");
      @(negedge clk); k0 = 1'b1; model_push(1'b0);
      repeat (5) @(negedge clk); k1 = 1'b1;
      repeat (5) @(negedge clk); k0 = 1'b0;
      repeat (8) @(negedge clk);
      check(unlock, 1'b1, "R5 handover held");
      k1 = 1'b0;
      repeat (4) @(negedge clk);
      check(unlock, 1'b1, "R5 handover single symbol");
      press(0, 4, "R8 next press closes");
      check(unlock, 1'b0, "R8 closed by next symbol");

      // R3: edge on which unlock responds
      do_reset();
      press(0, 4, "R3"); press(1, 4, "R3"); press(1, 4, "R3");
      @(negedge clk); k0 = 1'b1;
      @(negedge clk); @(negedge clk);
      check(unlock, 1'b0, "R3 not after two edges");
      @(negedge clk);
      check(unlock, 1'b1, "R3 after three edges");
      k0 = 1'b0;
      repeat (4) @(negedge clk);

      // R9: holding and releasing while open leaves unlock unchanged
      repeat (20) @(negedge clk);
      check(unlock, 1'b1, "R9 idle while open");

      // R2: reset clears an open lock
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      check(unlock, 1'b0, "R2 reset closes");
      rst = 1'b0;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule